// File: doc/BRIEF.md
# Serial PSRAM Power-Up Sequencer

This block takes an external serial pseudo-static RAM from an unknown state after reset into four-line command operation. It drives the chip select, the serial clock and four data lines with per-line output enables directly, and it needs no software help. One start pulse runs a fixed series of command frames. First it forces the device out of four-line mode. Next it reads the 24-bit device identification, retrying that read once if the first result is not valid. Then it sends a two-step reset and the command that enters four-line mode.

The captured identification is checked against a fixed signature byte. Its top byte is decoded into a capacity code. When the sequence finishes, the block raises `done` and shows the capacity code. If the identification fails twice, it raises `fail` instead and issues no further frames. Both flags hold until the next start pulse.

Each bit time on the serial clock lasts two system clock cycles. The clock is low in the first cycle and high in the second. Receive data is sampled at the end of the high cycle.

Top module: `psram_bringup_seq`

## Requirements
- R1: After a start pulse, the frames follow this order: 0xF5 (four-line), then 0x9F (read ID), then 0x66, 0x99 and 0x35. Each single-line frame other than read-ID carries exactly 8 clock pulses.
- R2: A four-line frame carries its byte in 2 clock pulses, upper nibble first on `sio_out[3:0]`, with `sio_oe` = 4'hF. `sio_oe` only ever takes the values 4'h0, 4'h1 or 4'hF.
- R3: A single-line frame shifts its opcode MSB first on `sio_out[0]` with `sio_oe` = 4'h1. The read-ID frame has 56 pulses in total: 8 opcode pulses, then 24 address pulses driving 0, then 24 receive pulses with `sio_oe` = 4'h0. During the receive pulses, `sio_in[1]` is captured MSB first.
- R4: An ID is valid only when its bits [15:8] equal 0x5D. If the first read-ID result is invalid, the read-ID frame is sent exactly once more before the reset frames.
- R5: If both reads are invalid, `fail` rises, `done` stays low and no further frame is issued.
- R6: The capacity code uses ID bits [23:21]. The value 000 gives code 0 (16 Mbit), 001 gives code 1 (32 Mbit), 010 gives code 2 (64 Mbit), and any other value gives code 3 (unknown).
- R7: When ID bits [23:16] equal 0x26, the capacity code is 2 (64 Mbit), regardless of R6.
- R8: Chip select stays high for at least 4 system cycles (two serial clock periods) between frames. `sclk` is low whenever `cs_n` is high.
- R9: `done` and `fail` are never high together. Each holds until the next start pulse. `cap_code` reads 0 whenever `done` is low. A start pulse while a sequence is running has no effect.
- R10: During and after reset, `cs_n` = 1, `sclk` = 0, `sio_oe` = 0, and `done`, `fail` and `cap_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| sio_in | input | 4 | Data lines from the device (line 1 carries ID data) |
| sio_out | output | 4 | Data lines to the device |
| sio_oe | output | 4 | Per-line output enable |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| done | output | 1 | Sequence completed, sticky |
| fail | output | 1 | ID check failed twice, sticky |
| cap_code | output | 2 | Capacity: 0=16M, 1=32M, 2=64M, 3=unknown |

## Verification
Some properties are checked every cycle. These are the framing invariants: the serial clock is idle while chip select is high, the minimum high time after each frame is met, only the three legal output-enable patterns appear, and the flags are exclusive, sticky and gate the capacity code. The other behaviours can only be shown by the bench's scenarios. These are the order of opcodes, the bit order within each frame, the single retry and the stop after a second failure, and the capacity decoding. To show them, the bench models a device that answers read-ID with chosen values and decodes every frame, and it sweeps all eight capacity field values plus the special extended-ID value.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EXITQ, ST_ID1, ST_ID2, ST_RSTEN, ST_RST, ST_ENTQ, ST_DONE, ST_FAIL
  } step_t;

  localparam logic [7:0] OP_EXIT_QUAD  = 8'hF5;
  localparam logic [7:0] OP_READ_ID    = 8'h9F;
  localparam logic [7:0] OP_RESET_EN   = 8'h66;
  localparam logic [7:0] OP_RESET      = 8'h99;
  localparam logic [7:0] OP_ENTER_QUAD = 8'h35;
  localparam logic [7:0] SIGNATURE     = 8'h5D;
  localparam logic [7:0] EXT_SPECIAL64 = 8'h26;

  // Signature byte sits in bits [15:8] of the captured identification.
  function automatic logic id_ok(input logic [23:0] id);
    return id[15:8] == SIGNATURE;
  endfunction

  // Capacity code from the extended byte: field [7:5], with one override.
  function automatic logic [1:0] cap_decode(input logic [7:0] ext);
    if (ext == EXT_SPECIAL64) return 2'd2;
    case (ext[7:5])
      3'b000:  return 2'd0;
      3'b001:  return 2'd1;
      3'b010:  return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic frame_step(input step_t s);
    return s inside {ST_EXITQ, ST_ID1, ST_ID2, ST_RSTEN, ST_RST, ST_ENTQ};
  endfunction

endpackage

// File: rtl/psram_frame_engine.sv
module psram_frame_engine #(
  parameter int ADDR_BITS = 24,
  parameter int RX_BITS   = 24,
  parameter int GAP_CYC   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               quad,
  input  logic [7:0]         opcode,
  input  logic               use_addr,
  input  logic               use_rx,
  input  logic [3:0]         sio_in,
  output logic               frame_end,
  output logic [RX_BITS-1:0] rx_word,
  output logic               cs_n,
  output logic               sclk,
  output logic [3:0]         sio_out,
  output logic [3:0]         sio_oe
);
  localparam int BEAT_MAX = 8 + ADDR_BITS + RX_BITS;
  localparam int BW = $clog2(BEAT_MAX + 1);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_t;
  eng_t             st;
  logic [BW-1:0]    beat;
  logic             phase;
  logic [GW-1:0]    gap_cnt;
  logic [RX_BITS-1:0] rx_sh;

  logic [BW-1:0] cmd_n, addr_end, tot;
  logic in_cmd, in_addr, in_rx, last_beat;
  logic [2:0] bit_sel;

  always_comb begin
    cmd_n     = quad ? BW'(2) : BW'(8);
    addr_end  = cmd_n + (use_addr ? BW'(ADDR_BITS) : '0);
    tot       = addr_end + (use_rx ? BW'(RX_BITS) : '0);
    in_cmd    = beat < cmd_n;
    in_addr   = !in_cmd && (beat < addr_end);
    in_rx     = beat >= addr_end;
    last_beat = beat == tot - BW'(1);
    bit_sel   = 3'd7 - beat[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; beat <= '0; phase <= 1'b0; gap_cnt <= '0; rx_sh <= '0;
    end else begin
      case (st)
        E_IDLE: if (go) begin
          st <= E_SHIFT; beat <= '0; phase <= 1'b0;
        end
        E_SHIFT: begin
          phase <= ~phase;
          if (phase) begin
            if (in_rx) rx_sh <= {rx_sh[RX_BITS-2:0], sio_in[1]};
            if (last_beat) begin
              st <= E_GAP; gap_cnt <= '0;
            end else begin
              beat <= beat + BW'(1);
            end
          end
        end
        E_GAP: begin
          if (gap_cnt == GW'(GAP_CYC - 1)) st <= E_IDLE;
          else gap_cnt <= gap_cnt + GW'(1);
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign frame_end = (st == E_GAP) && (gap_cnt == GW'(GAP_CYC - 1));
  assign rx_word   = rx_sh;
  assign cs_n      = (st != E_SHIFT);
  assign sclk      = (st == E_SHIFT) && phase;

  always_comb begin
    sio_out = 4'h0;
    sio_oe  = 4'h0;
    if (st == E_SHIFT) begin
      if (in_cmd && quad) begin
        sio_out = beat[0] ? opcode[3:0] : opcode[7:4];
        sio_oe  = 4'hF;
      end else if (in_cmd) begin
        sio_out = {3'b000, opcode[bit_sel]};
        sio_oe  = 4'h1;
      end else if (in_addr) begin
        sio_oe  = 4'h1;
      end
    end
  end
endmodule

// File: rtl/psram_step_ctrl.sv
module psram_step_ctrl
  import psram_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        frame_end,
  input  logic [23:0] rx_word,
  output logic        go,
  output logic        quad,
  output logic [7:0]  opcode,
  output logic        use_addr,
  output logic        use_rx,
  output logic        done,
  output logic        fail,
  output logic [23:0] id_q
);
  step_t step, nxt;
  logic  id_pass;

  assign id_pass = id_ok(rx_word);

  always_comb begin
    nxt = step;
    if (start && (step inside {ST_IDLE, ST_DONE, ST_FAIL})) begin
      nxt = ST_EXITQ;
    end else if (frame_end) begin
      case (step)
        ST_EXITQ: nxt = ST_ID1;
        ST_ID1:   nxt = id_pass ? ST_RSTEN : ST_ID2;
        ST_ID2:   nxt = id_pass ? ST_RSTEN : ST_FAIL;
        ST_RSTEN: nxt = ST_RST;
        ST_RST:   nxt = ST_ENTQ;
        ST_ENTQ:  nxt = ST_DONE;
        default:  nxt = step;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= ST_IDLE; go <= 1'b0; id_q <= '0;
    end else begin
      step <= nxt;
      go   <= (nxt != step) && frame_step(nxt);
      if (frame_end && (step inside {ST_ID1, ST_ID2}) && id_pass) id_q <= rx_word;
    end
  end

  always_comb begin
    quad = 1'b0; use_addr = 1'b0; use_rx = 1'b0; opcode = 8'h00;
    case (step)
      ST_EXITQ: begin opcode = OP_EXIT_QUAD; quad = 1'b1; end
      ST_ID1, ST_ID2: begin opcode = OP_READ_ID; use_addr = 1'b1; use_rx = 1'b1; end
      ST_RSTEN: opcode = OP_RESET_EN;
      ST_RST:   opcode = OP_RESET;
      ST_ENTQ:  opcode = OP_ENTER_QUAD;
      default:  opcode = 8'h00;
    endcase
  end

  assign done = (step == ST_DONE);
  assign fail = (step == ST_FAIL);
endmodule

// File: rtl/psram_bringup_seq.sv
module psram_bringup_seq
  import psram_seq_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] sio_in,
  output logic [3:0] sio_out,
  output logic [3:0] sio_oe,
  output logic       cs_n,
  output logic       sclk,
  output logic       done,
  output logic       fail,
  output logic [1:0] cap_code
);
  localparam int ID_BITS = 24;

  logic               go, quad, use_addr, use_rx, frame_end;
  logic [7:0]         opcode;
  logic [ID_BITS-1:0] rx_word, id_q;

  psram_step_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_end(frame_end),
    .rx_word(rx_word), .go(go), .quad(quad), .opcode(opcode),
    .use_addr(use_addr), .use_rx(use_rx), .done(done), .fail(fail), .id_q(id_q)
  );

  psram_frame_engine #(.ADDR_BITS(ID_BITS), .RX_BITS(ID_BITS), .GAP_CYC(GAP_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .quad(quad), .opcode(opcode),
    .use_addr(use_addr), .use_rx(use_rx), .sio_in(sio_in), .frame_end(frame_end),
    .rx_word(rx_word), .cs_n(cs_n), .sclk(sclk), .sio_out(sio_out), .sio_oe(sio_oe)
  );

  assign cap_code = done ? cap_decode(id_q[23:16]) : 2'd0;
endmodule

// File: rtl/psram_bringup_chk.sv
module psram_bringup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] sio_oe,
  input logic       done,
  input logic       fail,
  input logic [1:0] cap_code,
  input logic       frame_end
);
  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n ##1 cs_n ##1 cs_n);

  assert_frame_end_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> cs_n);

  assert_oe_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sio_oe == 4'h0) || (sio_oe == 4'h1) || (sio_oe == 4'hF));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  assert_cap_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (cap_code == 2'd0));

  assert_quiet_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> cs_n);
endmodule

bind psram_bringup_seq psram_bringup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sclk(sclk),
  .sio_oe(sio_oe), .done(done), .fail(fail), .cap_code(cap_code), .frame_end(frame_end)
);

// File: tb/psram_bringup_seq_tb.sv
`timescale 1ns/1ps
module psram_bringup_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] sio_in = 4'h0;
  logic [3:0] sio_out, sio_oe;
  logic       cs_n, sclk, done, fail;
  logic [1:0] cap_code;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  psram_bringup_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sio_in(sio_in), .sio_out(sio_out),
    .sio_oe(sio_oe), .cs_n(cs_n), .sclk(sclk), .done(done), .fail(fail), .cap_code(cap_code)
  );

  always #4 clk = ~clk;

  // ---------------- device model / frame monitor ----------------
  logic [7:0]  f_op [256];
  int          f_rises [256];
  bit          f_quad [256];
  int          nframes = 0;
  int          rises = 0;
  logic [7:0]  cmd = 8'h00;
  bit          quad_seen = 1'b0;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1;
  int          addr_err = 0, oe_err = 0, sclk_idle_err = 0;
  int          hi_run = 0, min_gap = 1000;
  int          id_reads = 0, rd_base = 0;
  logic [23:0] id_a = 24'h0, id_b = 24'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && sclk) sclk_idle_err++;
      if (prev_cs && !cs_n) begin
        if (nframes > 0 && hi_run < min_gap) min_gap = hi_run;
        rises = 0; cmd = 8'h00; quad_seen = 1'b0;
      end
      if (cs_n) hi_run++; else hi_run = 0;
      if (!cs_n && sclk && !prev_sclk) begin
        if (sio_oe == 4'hF) begin
          quad_seen = 1'b1; cmd = {cmd[3:0], sio_out};
        end else if (rises < 8) begin
          if (sio_oe != 4'h1) oe_err++;
          cmd = {cmd[6:0], sio_out[0]};
        end else if (rises < 32) begin
          if (sio_oe != 4'h1 || sio_out[0]) addr_err++;
        end else begin
          if (sio_oe != 4'h0) oe_err++;
        end
        rises++;
      end
      if (!cs_n && cmd == 8'h9F && rises >= 33 && rises <= 56)
        sio_in[1] = ((id_reads - rd_base) == 0) ? id_a[56 - rises] : id_b[56 - rises];
      else
        sio_in[1] = 1'b0;
      if (!prev_cs && cs_n) begin
        f_op[nframes] = cmd; f_rises[nframes] = rises; f_quad[nframes] = quad_seen;
        nframes++;
        if (cmd == 8'h9F) id_reads++;
      end
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  function automatic int exp_cap(input logic [7:0] ext);
    int fld;
    fld = int'(ext) / 32;
    if (ext == 8'h26) return 2;
    return (fld < 3) ? fld : 3;
  endfunction

  // mode 0: first ID good, 1: second ID good, 2: both bad
  task automatic run_case(input logic [23:0] a, input logic [23:0] b, input bit restart_mid);
    logic [7:0] eops [6];
    int ne, base, mode, ecap, n;
    bit a_ok, b_ok;
    a_ok = (a[15:8] == 8'h5D);
    b_ok = (b[15:8] == 8'h5D);
    mode = a_ok ? 0 : (b_ok ? 1 : 2);
    id_a = a; id_b = b; rd_base = id_reads;
    base = nframes;
    if (mode == 0) begin
      ne = 5; eops[0] = 8'hF5; eops[1] = 8'h9F; eops[2] = 8'h66; eops[3] = 8'h99; eops[4] = 8'h35;
      ecap = exp_cap(a[23:16]);
    end else if (mode == 1) begin
      ne = 6; eops[0] = 8'hF5; eops[1] = 8'h9F; eops[2] = 8'h9F; eops[3] = 8'h66; eops[4] = 8'h99; eops[5] = 8'h35;
      ecap = exp_cap(b[23:16]);
    end else begin
      ne = 3; eops[0] = 8'hF5; eops[1] = 8'h9F; eops[2] = 8'h9F;
      ecap = 0;
    end
    pulse_start();
    @(negedge clk);
    chk(!done && !fail, "R9 flags cleared by start", {done, fail}, 0);
    chk(cap_code == 2'd0, "R9 cap zero while busy", cap_code, 0);
    if (restart_mid) begin
      repeat (100) @(negedge clk);
      pulse_start();
    end
    n = 0;
    while (!(done || fail) && n < 5000) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
    chk(nframes - base == ne, "R1 frame count", nframes - base, ne);
    for (int i = 0; i < 6; i++) begin
      if (i < ne && base + i < nframes) begin
        chk(f_op[base+i] == eops[i], "R1 opcode order", f_op[base+i], eops[i]);
        chk(f_quad[base+i] == (eops[i] == 8'hF5), "R2 four-line only for exit", f_quad[base+i], eops[i] == 8'hF5);
        chk(f_rises[base+i] == ((eops[i] == 8'hF5) ? 2 : (eops[i] == 8'h9F) ? 56 : 8),
            "R3 pulse count", f_rises[base+i], (eops[i] == 8'hF5) ? 2 : (eops[i] == 8'h9F) ? 56 : 8);
      end
    end
    if (mode == 2) begin
      chk(fail && !done, "R5 fail after two bad IDs", {done, fail}, 1);
    end else begin
      chk(done && !fail, "R4 done after good ID", {done, fail}, 2);
    end
    chk(cap_code == 2'(ecap), (a[23:16] == 8'h26 || b[23:16] == 8'h26) ? "R7 special ext id" : "R6 capacity", cap_code, ecap);
    base = nframes;
    repeat (30) @(negedge clk);
    chk(nframes == base, "R5 no frames after end", nframes - base, 0);
    chk(done == (mode != 2) && fail == (mode == 2), "R9 flags sticky", {done, fail}, (mode == 2) ? 1 : 2);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && sio_oe == 4'h0, "R10 pins in reset", {cs_n, sclk, sio_oe}, 6'b100000);
    chk(!done && !fail && cap_code == 2'd0, "R10 flags in reset", {done, fail, cap_code}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && !done && !fail, "R10 idle after reset", {cs_n, done, fail}, 3'b100);

    // R6 sweep of all eight capacity field values, first read good
    for (int k = 0; k < 8; k++) run_case({3'(k), 5'b01010, 8'h5D, 8'hA5}, 24'h0, 1'b0);
    // R7 special value and its neighbour
    run_case({8'h26, 8'h5D, 8'h3C}, 24'h0, 1'b0);
    run_case({8'h27, 8'h5D, 8'h3C}, 24'h0, 1'b0);
    // R4 retry: near-miss signatures on the first read
    run_case({8'h40, 8'h5C, 8'h00}, {8'h20, 8'h5D, 8'hFF}, 1'b0);
    run_case({8'h40, 8'hDD, 8'h5D}, {8'h26, 8'h5D, 8'h00}, 1'b0);
    // R5 both reads bad
    run_case({8'h40, 8'h00, 8'h5D}, {8'h5D, 8'h5E, 8'h5D}, 1'b0);
    // recovery after fail, and R9 start ignored mid-run
    run_case({8'h00, 8'h5D, 8'h00}, 24'h0, 1'b1);

    chk(addr_err == 0, "R3 address bits zero", addr_err, 0);
    chk(oe_err == 0, "R3 output enable per phase", oe_err, 0);
    chk(sclk_idle_err == 0, "R8 sclk low while deselected", sclk_idle_err, 0);
    chk(min_gap >= 4, "R8 deselect gap", min_gap, 4);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule